// File: doc/BRIEF.md
# Virtual Address Region Decoder

This block is the first stage of a 32-bit address translation path. Each virtual address is sorted into a region of a fixed segmented map. The region, together with the privilege level, the access type (instruction fetch or data) and the translation-enable bit, selects one of three outcomes:

- a direct physical mapping, decided locally;
- forwarding to an external TLB unit;
- an address error.

A probe flag changes every error outcome into a quiet result, so that a debugger or table walker can ask about an address without raising a fault.

A request is taken on a strobe while the block is ready. A local decision appears as a one-cycle response pulse on the next cycle. A forwarded request is raised on the TLB port and held there until the TLB answers. The answer then comes out on the response port one cycle later, and no new request is taken while one is outstanding.

Top module: `va_region_decode`

## Requirements
- R1: In the translated regions (bit 31 clear, or 0xC0000000 to 0xDFFFFFFF) with translation disabled, the response carries physical address = vaddr AND 0x1FFFFFFF and status read/write (2), in any mode and for any access type.
- R2: In the translated regions with translation enabled, tlb_req rises one cycle after the strobe with tlb_vaddr, tlb_priv, tlb_ifetch and tlb_probe copied from the request. It stays high with stable fields until tlb_rsp_valid. One cycle after tlb_rsp_valid, the response carries tlb_rsp_paddr and tlb_rsp_status with no error, and req_ready is low while the request is outstanding.
- R3: Addresses 0xE0000000 to 0xE3FFFFFF pass through unchanged with status read/write, for either privilege and either access type.
- R4: In privileged mode, addresses 0x80000000 to 0xBFFFFFFF map to vaddr AND 0x1FFFFFFF with status read/write.
- R5: In privileged mode, a data access at 0xF0000000 or above passes through unchanged with status read/write. An instruction fetch there is an error.
- R6: Any access to 0xE4000000 to 0xEFFFFFFF is an error.
- R7: In user mode, any address from 0x80000000 to 0xBFFFFFFF or from 0xE4000000 upward is an error.
- R8: An error response has rsp_addr_err = 1, status no-access (0) and physical address 0. Status codes are 0 no-access, 1 read-only, 2 read/write, and 3 never appears.
- R9: With req_probe set, every error case instead returns status read/write, physical address 0 and rsp_addr_err = 0.
- R10: After reset, rsp_valid and tlb_req are 0 and req_ready is 1. A locally decided request gives exactly one rsp_valid pulse, on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_vaddr | input | 32 | Virtual address |
| req_priv | input | 1 | Privileged mode |
| req_ifetch | input | 1 | Access is an instruction fetch |
| req_xlat_en | input | 1 | Address translation enabled |
| req_probe | input | 1 | Probe: suppress address errors |
| req_ready | output | 1 | Block can take a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_status | output | 2 | 0 no access, 1 read-only, 2 read/write |
| rsp_addr_err | output | 1 | Address error |
| tlb_req | output | 1 | Held request to the TLB unit |
| tlb_vaddr | output | 32 | Address forwarded to the TLB |
| tlb_priv | output | 1 | Privilege forwarded to the TLB |
| tlb_ifetch | output | 1 | Access type forwarded to the TLB |
| tlb_probe | output | 1 | Probe flag forwarded to the TLB |
| tlb_rsp_valid | input | 1 | TLB answer strobe |
| tlb_rsp_paddr | input | 32 | TLB physical address |
| tlb_rsp_status | input | 2 | TLB access status |

## Verification
A local decision is due on the cycle right after its strobe. The driver stamps each expected item with that cycle, and the monitor rejects a pulse that arrives on any other cycle. A forwarded request has no fixed due cycle, because it depends on the TLB stub, which answers two cycles after it sees tlb_req. Its expected item therefore carries no stamp and is matched by order. In the cycle after each forward, the bench also checks that tlb_req is high and req_ready is low.

// File: rtl/va_dec_pkg.sv
package va_dec_pkg;

    localparam int VA_W = 32;

    typedef enum logic [2:0] {
        SEG_XLAT_LO,
        SEG_DIRECT,
        SEG_XLAT_HI,
        SEG_SQ,
        SEG_GAP,
        SEG_CTRL
    } seg_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RO   = 2'd1,
        ACC_RW   = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ROUTE_MAP,
        ROUTE_TLB,
        ROUTE_FAULT
    } route_e;

    typedef struct packed {
        route_e          route;
        logic [VA_W-1:0] paddr;
        acc_e            acc;
        logic            err;
    } res_t;

    function automatic logic [VA_W-1:0] keep_low(input logic [VA_W-1:0] va, input int keep_w);
        logic [VA_W-1:0] m;
        m = '0;
        for (int i = 0; i < VA_W; i++) begin
            if (i < keep_w) m[i] = 1'b1;
        end
        return va & m;
    endfunction

endpackage

// File: rtl/va_seg_classify.sv
module va_seg_classify
    import va_dec_pkg::*;
(
    input  logic [5:0] va_top,
    output seg_e       seg
);
    always_comb begin
        if (!va_top[5])                 seg = SEG_XLAT_LO;
        else if (va_top[5:4] == 2'b10)  seg = SEG_DIRECT;
        else if (!va_top[3])            seg = SEG_XLAT_HI;
        else if (va_top[2:0] == 3'b000) seg = SEG_SQ;
        else if (va_top[2])             seg = SEG_CTRL;
        else                            seg = SEG_GAP;
    end
endmodule

// File: rtl/va_route_resolve.sv
module va_route_resolve
    import va_dec_pkg::*;
#(
    parameter int PA_KEEP_W = 29
) (
    input  seg_e            seg,
    input  logic [VA_W-1:0] vaddr,
    input  logic            priv,
    input  logic            ifetch,
    input  logic            xlat_en,
    input  logic            probe,
    output res_t            res
);
    logic [VA_W-1:0] direct_pa;
    logic            fault;

    assign direct_pa = keep_low(vaddr, PA_KEEP_W);

    always_comb begin
        fault     = 1'b0;
        res.route = ROUTE_MAP;
        res.paddr = '0;
        res.acc   = ACC_RW;
        res.err   = 1'b0;
        unique case (seg)
            SEG_XLAT_LO, SEG_XLAT_HI: begin
                if (xlat_en) res.route = ROUTE_TLB;
                else         res.paddr = direct_pa;
            end
            SEG_SQ:     res.paddr = vaddr;
            SEG_DIRECT: begin
                if (priv) res.paddr = direct_pa;
                else      fault = 1'b1;
            end
            SEG_CTRL: begin
                if (priv && !ifetch) res.paddr = vaddr;
                else                 fault = 1'b1;
            end
            default: fault = 1'b1;
        endcase
        if (fault) begin
            res.route = ROUTE_FAULT;
            res.paddr = '0;
            res.acc   = probe ? ACC_RW : ACC_NONE;
            res.err   = !probe;
        end
    end
endmodule

// File: rtl/va_rsp_stage.sv
module va_rsp_stage
    import va_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_priv,
    input  logic            req_ifetch,
    input  logic            req_probe,
    input  res_t            res,
    output logic            req_ready,
    output logic            rsp_valid,
    output logic [VA_W-1:0] rsp_paddr,
    output acc_e            rsp_acc,
    output logic            rsp_err,
    output logic            tlb_req,
    output logic [VA_W-1:0] tlb_vaddr,
    output logic            tlb_priv,
    output logic            tlb_ifetch,
    output logic            tlb_probe,
    input  logic            tlb_rsp_valid,
    input  logic [VA_W-1:0] tlb_rsp_paddr,
    input  logic [1:0]      tlb_rsp_status
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;
    st_e  st_q;
    logic accept;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            rsp_valid  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_acc    <= ACC_NONE;
            rsp_err    <= 1'b0;
            tlb_req    <= 1'b0;
            tlb_vaddr  <= '0;
            tlb_priv   <= 1'b0;
            tlb_ifetch <= 1'b0;
            tlb_probe  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (res.route == ROUTE_TLB) begin
                            st_q       <= ST_WAIT;
                            tlb_req    <= 1'b1;
                            tlb_vaddr  <= req_vaddr;
                            tlb_priv   <= req_priv;
                            tlb_ifetch <= req_ifetch;
                            tlb_probe  <= req_probe;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_paddr <= res.paddr;
                            rsp_acc   <= res.acc;
                            rsp_err   <= res.err;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tlb_rsp_valid) begin
                        st_q      <= ST_IDLE;
                        tlb_req   <= 1'b0;
                        rsp_valid <= 1'b1;
                        rsp_paddr <= tlb_rsp_paddr;
                        rsp_acc   <= acc_e'(tlb_rsp_status);
                        rsp_err   <= 1'b0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/va_region_decode.sv
module va_region_decode
    import va_dec_pkg::*;
#(
    parameter int PA_KEEP_W = 29
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [31:0]     req_vaddr,
    input  logic            req_priv,
    input  logic            req_ifetch,
    input  logic            req_xlat_en,
    input  logic            req_probe,
    output logic            req_ready,
    output logic            rsp_valid,
    output logic [31:0]     rsp_paddr,
    output logic [1:0]      rsp_status,
    output logic            rsp_addr_err,
    output logic            tlb_req,
    output logic [31:0]     tlb_vaddr,
    output logic            tlb_priv,
    output logic            tlb_ifetch,
    output logic            tlb_probe,
    input  logic            tlb_rsp_valid,
    input  logic [31:0]     tlb_rsp_paddr,
    input  logic [1:0]      tlb_rsp_status
);
    localparam int TOP_BITS = 6;

    seg_e seg;
    res_t res;
    acc_e rsp_acc;

    va_seg_classify u_cls (
        .va_top (req_vaddr[VA_W-1 -: TOP_BITS]),
        .seg    (seg)
    );

    va_route_resolve #(.PA_KEEP_W(PA_KEEP_W)) u_res (
        .seg     (seg),
        .vaddr   (req_vaddr),
        .priv    (req_priv),
        .ifetch  (req_ifetch),
        .xlat_en (req_xlat_en),
        .probe   (req_probe),
        .res     (res)
    );

    va_rsp_stage u_stg (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .req_priv       (req_priv),
        .req_ifetch     (req_ifetch),
        .req_probe      (req_probe),
        .res            (res),
        .req_ready      (req_ready),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_acc        (rsp_acc),
        .rsp_err        (rsp_addr_err),
        .tlb_req        (tlb_req),
        .tlb_vaddr      (tlb_vaddr),
        .tlb_priv       (tlb_priv),
        .tlb_ifetch     (tlb_ifetch),
        .tlb_probe      (tlb_probe),
        .tlb_rsp_valid  (tlb_rsp_valid),
        .tlb_rsp_paddr  (tlb_rsp_paddr),
        .tlb_rsp_status (tlb_rsp_status)
    );

    assign rsp_status = rsp_acc;
endmodule

// File: rtl/va_region_decode_chk.sv
module va_region_decode_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        req_probe,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic [1:0]  rsp_status,
    input logic        rsp_addr_err,
    input logic        tlb_req,
    input logic [31:0] tlb_vaddr,
    input logic        tlb_rsp_valid
);
    AST_TLB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tlb_req && !tlb_rsp_valid) |=> (tlb_req && $stable(tlb_vaddr))); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        tlb_req |-> !req_ready); // R2

    AST_SQ_PASS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_vaddr[31:26] == 6'b111000)
        |=> (rsp_valid && rsp_paddr == $past(req_vaddr) && rsp_status == 2'd2)); // R3

    AST_ERR_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_addr_err) |-> (rsp_status == 2'd0 && rsp_paddr == 32'd0)); // R8

    AST_NO_ERR_ON_PROBE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_addr_err) |-> $past(!req_probe)); // R9

    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(tlb_req && tlb_rsp_valid))); // R10

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status != 2'd3)); // R8
endmodule

bind va_region_decode va_region_decode_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_probe     (req_probe),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_status    (rsp_status),
    .rsp_addr_err  (rsp_addr_err),
    .tlb_req       (tlb_req),
    .tlb_vaddr     (tlb_vaddr),
    .tlb_rsp_valid (tlb_rsp_valid)
);

// File: tb/test_va_region_decode.sv
module test_va_region_decode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_priv = 1'b0, req_ifetch = 1'b0, req_xlat_en = 1'b0, req_probe = 1'b0;
    logic        req_ready, rsp_valid, rsp_addr_err;
    logic [31:0] rsp_paddr, tlb_vaddr;
    logic [1:0]  rsp_status;
    logic        tlb_req, tlb_priv, tlb_ifetch, tlb_probe;
    logic        tlb_rsp_valid = 1'b0;
    logic [31:0] tlb_rsp_paddr = '0;
    logic [1:0]  tlb_rsp_status = '0;

    int checks = 0, fails = 0, cyc = 0, stub_wait = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] pa;
        logic [1:0]  st;
        logic        err;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    va_region_decode i_va_region_decode (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Stub TLB: answers two cycles after it sees tlb_req; paddr = {3'b001, va[28:0]},
    // status read-only for a fetch, read/write for data.
    initial forever begin
        @(negedge clk);
        if (tlb_rsp_valid) begin
            tlb_rsp_valid = 1'b0;
            stub_wait = 0;
        end else if (tlb_req) begin
            stub_wait++;
            if (stub_wait == 2) begin
                tlb_rsp_valid  = 1'b1;
                tlb_rsp_paddr  = {3'b001, tlb_vaddr[28:0]};
                tlb_rsp_status = tlb_ifetch ? 2'd1 : 2'd2;
            end
        end
    end

    function automatic exp_t model(input logic [31:0] va, input bit pv, input bit fi,
                                   input bit xl, input bit pb, output bit fwd);
        exp_t e;
        bit bad = 0;
        fwd = 0;
        e.pa = '0; e.st = 2'd2; e.err = 0; e.due = -1; e.tag = "";
        if (!va[31] || (va >= 32'hC000_0000 && va < 32'hE000_0000)) begin
            if (xl) begin
                fwd = 1; e.pa = {3'b001, va[28:0]}; e.st = fi ? 2'd1 : 2'd2; e.tag = "R2";
            end else begin
                e.pa = va & 32'h1FFF_FFFF; e.tag = "R1";
            end
        end else if (va >= 32'hE000_0000 && va < 32'hE400_0000) begin
            e.pa = va; e.tag = "R3";
        end else if (!pv) begin
            bad = 1; e.tag = "R7";
        end else if (va < 32'hC000_0000) begin
            e.pa = va & 32'h1FFF_FFFF; e.tag = "R4";
        end else if (va >= 32'hF000_0000) begin
            if (fi) bad = 1;
            else e.pa = va;
            e.tag = "R5";
        end else begin
            bad = 1; e.tag = "R6";
        end
        if (bad) begin
            e.pa = '0;
            e.st = pb ? 2'd2 : 2'd0;
            e.err = !pb;
            if (pb) e.tag = "R9";
        end
        return e;
    endfunction

    task automatic send(input logic [31:0] va, input bit pv, input bit fi,
                        input bit xl, input bit pb);
        exp_t e;
        bit fwd;
        while (!req_ready) @(negedge clk);
        e = model(va, pv, fi, xl, pb, fwd);
        if (!fwd) e.due = cyc + 1;
        sb.push_back(e);
        req_valid = 1; req_vaddr = va; req_priv = pv; req_ifetch = fi;
        req_xlat_en = xl; req_probe = pb;
        @(negedge clk);
        req_valid = 0;
        if (fwd) begin
            chk(tlb_req && !req_ready && tlb_vaddr == va && tlb_ifetch == fi,
                "R2", "tlb_req/ready/vaddr", {tlb_req, req_ready, tlb_vaddr}, {1'b1, 1'b0, va});
        end
    endtask

    // Monitor
    initial forever begin
        @(negedge clk);
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R10", "unexpected rsp_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_paddr == e.pa, e.tag, "paddr", rsp_paddr, e.pa);
                chk(rsp_status == e.st, e.tag, "status", rsp_status, e.st);
                chk(rsp_addr_err == e.err, e.err ? "R8" : e.tag, "addr_err", rsp_addr_err, e.err);
                if (e.due >= 0)
                    chk(cyc == e.due, "R10", "response cycle", cyc, e.due);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!rsp_valid && !tlb_req && req_ready, "R10", "reset state",
            {rsp_valid, tlb_req, req_ready}, 3'b001);

        // R1: translated, translation off
        send(32'h0000_0000, 0, 0, 0, 0);
        send(32'h7FFF_FFFF, 0, 1, 0, 0);
        send(32'hC000_0000, 1, 0, 0, 0);
        send(32'hDFFF_FFFF, 0, 0, 0, 0);
        // R2: forwarded to TLB
        send(32'h1234_5678, 0, 0, 1, 0);
        send(32'hC765_4321, 1, 1, 1, 0);
        send(32'h0000_1000, 0, 0, 1, 1);
        // R3: store-queue window
        send(32'hE000_0000, 0, 1, 0, 0);
        send(32'hE3FF_FFFC, 1, 0, 1, 0);
        // R4: direct map, privileged
        send(32'h8000_0000, 1, 0, 1, 0);
        send(32'hBFFF_FFFF, 1, 1, 0, 0);
        send(32'hA123_4560, 1, 0, 0, 0);
        // R5: control window
        send(32'hF000_0000, 1, 0, 0, 0);
        send(32'hFFFF_FFFF, 1, 0, 1, 0);
        send(32'hFF00_0010, 1, 1, 0, 0);
        // R6: gap
        send(32'hE400_0000, 1, 0, 0, 0);
        send(32'hEFFF_FFFF, 1, 1, 0, 0);
        // R7: user-mode errors
        send(32'h8000_0000, 0, 0, 0, 0);
        send(32'hBFFF_FFFF, 0, 0, 1, 0);
        send(32'hF000_0000, 0, 0, 0, 0);
        send(32'hE400_0000, 0, 1, 0, 0);
        // R9: probe suppresses errors
        send(32'h9000_0000, 0, 0, 0, 1);
        send(32'hE800_0000, 1, 0, 0, 1);
        send(32'hF123_0000, 1, 1, 0, 1);
        // back-to-back mix after a forward
        send(32'h4000_0040, 1, 1, 1, 0);
        send(32'h8000_1234, 1, 0, 0, 0);

        repeat (8) @(negedge clk);
        chk(sb.size() == 0, "R10", "pending responses", sb.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule